// File: doc/BRIEF.md
# Dual Potentiometer Wiper Controller

This block keeps the wiper settings of two digitally controlled potentiometers. Wiper A belongs to a 100-position device and is a 7-bit register. Wiper B belongs to a 256-position device and is an 8-bit register. Each wiper is a volatile register with a nonvolatile shadow behind it. After every reset the block copies each shadow into its wiper.

Write commands come in already decoded from a serial-bus front end. A volatile write changes only the addressed wiper, and it takes effect on the next clock edge. A nonvolatile write is allowed only while the write enable latch input is high. It starts a busy period of a parameterised length. When that period ends, the shadow and the wiper are updated together. Any write can load any value, so the block never steps through the positions in between.

A separate combinational path turns a requested position index for the 100-position device into that device's segmented register code. The sequencer has three states:

- `ST_RECALL` is the state the block enters from reset. It copies the shadows into the wipers and then moves on to `ST_IDLE`. This is the recall transition.
- `ST_IDLE` takes commands. A nonvolatile write with the latch set moves to `ST_NV_BUSY`. This is the start transition.
- `ST_NV_BUSY` counts down. When the count runs out, it commits the update and returns to `ST_IDLE`. This is the commit transition.

Top module: `dual_pot_wiper_ctrl`

## Requirements
- R1: While reset is asserted, `busy` is 1 and both wipers read 0.
- R2: On the first clock edge after reset is released, each wiper is loaded from its shadow and `busy` falls. The shadows keep their contents through reset. At time zero they hold the parameter values `SHADOW_A_INIT` (default 20) and `SHADOW_B_INIT` (default 128).
- R3: A volatile write changes only the wiper selected by `cmd_sel`, and the new value is visible one clock edge later. `cmd_sel` = 0 selects wiper A, which takes `cmd_data[6:0]`. `cmd_sel` = 1 selects wiper B, which takes all of `cmd_data`.
- R4: A volatile write leaves the shadow unchanged. After the next reset the wiper shows the shadow value again.
- R5: A nonvolatile write (`cmd_nv` = 1) issued while `wel` = 0 has no effect: `busy` stays 0, and neither the wipers nor the shadows change.
- R6: A nonvolatile write with `wel` = 1 holds `busy` high for exactly `NV_CYCLES` cycles (default 8). When `busy` falls, both the selected wiper and its shadow hold the written value.
- R7: Any command presented while `busy` is 1 is ignored.
- R8: Consecutive writes to a wiper may differ in any number of bits, and each value is loaded directly.
- R9: `tap_code` is computed from the signed index `tap_req` with no clock delay:
  - index below 0 gives 0;
  - 0 to 24 gives the index itself;
  - 25 to 49 gives 88 minus the index;
  - 50 to 74 gives the index plus 14;
  - 75 to 99 gives 195 minus the index;
  - index above 99 gives 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded write command present this cycle |
| cmd_sel | input | 1 | Wiper select: 0 selects A (100-position), 1 selects B (256-position) |
| cmd_nv | input | 1 | 1 selects a nonvolatile write, 0 a volatile write |
| cmd_data | input | 8 | Register value to write |
| wel | input | 1 | Write enable latch state |
| tap_req | input | 8 | Signed position index for the 100-position device |
| tap_code | output | 7 | Register code for `tap_req` |
| wiper_a | output | 7 | Wiper A register |
| wiper_b | output | 8 | Wiper B register |
| busy | output | 1 | Recall or nonvolatile write in progress |

## Verification
The assertions assume that `cmd_sel`, `cmd_nv`, `cmd_data` and `wel` carry known values in every cycle in which `cmd_valid` is high. They also assume `tap_req` is always driven. The stimulus meets both conditions by changing every input only on the falling clock edge. It parks all the command inputs at fixed values when no command is being sent. The encoder is swept over all 256 signed index values, so the clamp boundaries on both sides are covered.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int A_W   = 7;
    localparam int B_W   = 8;
    localparam int IDX_W = 8;

    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_NV_BUSY = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic           sel;
        logic [B_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/tap_encoder.sv
module tap_encoder
    import wiper_pkg::*;
#(
    parameter int TAPS    = 100,
    parameter int SEG     = 25,
    parameter int CLAMP_HI = 96
) (
    input  logic signed [IDX_W-1:0] idx,
    output logic        [A_W-1:0]   code
);

    localparam int LAST = TAPS - 1;

    int v;
    int r;

    always_comb begin
        v = int'(idx);
        if (v < 0) begin
            r = 0;
        end else if (v > LAST) begin
            r = CLAMP_HI;
        end else if (v < SEG) begin
            r = v;
        end else if (v < 2 * SEG) begin
            r = 88 - v;
        end else if (v < 3 * SEG) begin
            r = v + 14;
        end else begin
            r = 195 - v;
        end
        code = r[A_W-1:0];
    end

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq
    import wiper_pkg::*;
#(
    parameter int NV_CYCLES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_sel,
    input  logic           cmd_nv,
    input  logic [B_W-1:0] cmd_data,
    input  logic           wel,
    output logic           recall,
    output logic           vol_we,
    output logic           nv_commit,
    output wr_req_t        pend,
    output logic           busy
);

    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    ctl_state_e       state;
    ctl_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             nv_start;

    assign nv_start = (state == ST_IDLE) && cmd_valid && cmd_nv && wel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RECALL;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RECALL:  nxt = ST_IDLE;
            ST_IDLE:    if (nv_start) nxt = ST_NV_BUSY;
            ST_NV_BUSY: if (cnt == '0) nxt = ST_IDLE;
            default:    nxt = ST_RECALL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= '0;
        end else if (nv_start) begin
            cnt  <= CNT_W'(NV_CYCLES - 1);
            pend <= '{sel: cmd_sel, data: cmd_data};
        end else if (state == ST_NV_BUSY && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        recall    = 1'b0;
        vol_we    = 1'b0;
        nv_commit = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_RECALL:  recall = 1'b1;
            ST_IDLE: begin
                busy   = 1'b0;
                vol_we = cmd_valid && !cmd_nv;
            end
            ST_NV_BUSY: nv_commit = (cnt == '0);
            default:    busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/nv_shadow.sv
module nv_shadow
    import wiper_pkg::*;
#(
    parameter logic [A_W-1:0] SHADOW_A_INIT = 7'd20,
    parameter logic [B_W-1:0] SHADOW_B_INIT = 8'd128
) (
    input  logic           clk,
    input  logic           nv_commit,
    input  wr_req_t        pend,
    output logic [A_W-1:0] shadow_a,
    output logic [B_W-1:0] shadow_b
);

    logic [A_W-1:0] sa = SHADOW_A_INIT;
    logic [B_W-1:0] sb = SHADOW_B_INIT;

    always_ff @(posedge clk) begin
        if (nv_commit) begin
            if (pend.sel) sb <= pend.data;
            else          sa <= pend.data[A_W-1:0];
        end
    end

    assign shadow_a = sa;
    assign shadow_b = sb;

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wiper_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           recall,
    input  logic           vol_we,
    input  logic           cmd_sel,
    input  logic [B_W-1:0] cmd_data,
    input  logic           nv_commit,
    input  wr_req_t        pend,
    input  logic [A_W-1:0] shadow_a,
    input  logic [B_W-1:0] shadow_b,
    output logic [A_W-1:0] wiper_a,
    output logic [B_W-1:0] wiper_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_a <= '0;
            wiper_b <= '0;
        end else if (recall) begin
            wiper_a <= shadow_a;
            wiper_b <= shadow_b;
        end else if (nv_commit) begin
            if (pend.sel) wiper_b <= pend.data;
            else          wiper_a <= pend.data[A_W-1:0];
        end else if (vol_we) begin
            if (cmd_sel) wiper_b <= cmd_data;
            else         wiper_a <= cmd_data[A_W-1:0];
        end
    end

endmodule

// File: rtl/dual_pot_wiper_ctrl.sv
module dual_pot_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int              NV_CYCLES     = 8,
    parameter logic [A_W-1:0]  SHADOW_A_INIT = 7'd20,
    parameter logic [B_W-1:0]  SHADOW_B_INIT = 8'd128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_sel,
    input  logic                    cmd_nv,
    input  logic [B_W-1:0]          cmd_data,
    input  logic                    wel,
    input  logic signed [IDX_W-1:0] tap_req,
    output logic [A_W-1:0]          tap_code,
    output logic [A_W-1:0]          wiper_a,
    output logic [B_W-1:0]          wiper_b,
    output logic                    busy
);

    logic           recall;
    logic           vol_we;
    logic           nv_commit;
    wr_req_t        pend;
    logic [A_W-1:0] shadow_a;
    logic [B_W-1:0] shadow_b;

    wiper_seq #(.NV_CYCLES(NV_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_nv(cmd_nv), .cmd_data(cmd_data), .wel(wel), .recall(recall),
        .vol_we(vol_we), .nv_commit(nv_commit), .pend(pend), .busy(busy)
    );

    nv_shadow #(.SHADOW_A_INIT(SHADOW_A_INIT), .SHADOW_B_INIT(SHADOW_B_INIT)) u_nv (
        .clk(clk), .nv_commit(nv_commit), .pend(pend),
        .shadow_a(shadow_a), .shadow_b(shadow_b)
    );

    wiper_bank u_bank (
        .clk(clk), .rst_n(rst_n), .recall(recall), .vol_we(vol_we),
        .cmd_sel(cmd_sel), .cmd_data(cmd_data), .nv_commit(nv_commit),
        .pend(pend), .shadow_a(shadow_a), .shadow_b(shadow_b),
        .wiper_a(wiper_a), .wiper_b(wiper_b)
    );

    tap_encoder u_enc (
        .idx(tap_req), .code(tap_code)
    );

endmodule

// File: rtl/wiper_chk.sv
module wiper_chk
    import wiper_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic                    cmd_sel,
    input logic                    cmd_nv,
    input logic [B_W-1:0]          cmd_data,
    input logic                    wel,
    input logic signed [IDX_W-1:0] tap_req,
    input logic [A_W-1:0]          tap_code,
    input logic [A_W-1:0]          wiper_a,
    input logic [B_W-1:0]          wiper_b,
    input logic                    busy
);

    AST_RESET_BUSY: assert property (@(posedge clk) !rst_n |-> busy && wiper_a == '0 && wiper_b == '0); // R1

    AST_VOL_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_nv && !busy && !cmd_sel |=> wiper_a == $past(cmd_data[A_W-1:0]) && $stable(wiper_b)); // R3

    AST_VOL_WRITE_B: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_nv && !busy && cmd_sel |=> wiper_b == $past(cmd_data) && $stable(wiper_a)); // R3

    AST_NV_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_nv && !wel && !busy |=> !busy && $stable(wiper_a) && $stable(wiper_b)); // R5

    AST_NV_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_nv && wel && !busy |=> busy); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && $past(rst_n) |=> !busy || ($stable(wiper_a) && $stable(wiper_b))); // R7

    AST_ENC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tap_req < 0 |-> tap_code == '0); // R9

    AST_ENC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tap_req > 8'sd99 |-> tap_code == 7'd96); // R9

    AST_ENC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_code <= 7'd120); // R9

endmodule

bind dual_pot_wiper_ctrl wiper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_nv(cmd_nv), .cmd_data(cmd_data), .wel(wel), .tap_req(tap_req),
    .tap_code(tap_code), .wiper_a(wiper_a), .wiper_b(wiper_b), .busy(busy)
);

// File: tb/sim_dual_pot_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_dual_pot_wiper_ctrl;

    localparam int NVC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_sel = 1'b0;
    logic              cmd_nv = 1'b0;
    logic [7:0]        cmd_data = 8'd0;
    logic              wel = 1'b0;
    logic signed [7:0] tap_req = 8'sd0;
    logic [6:0]        tap_code;
    logic [6:0]        wiper_a;
    logic [7:0]        wiper_b;
    logic              busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_pot_wiper_ctrl #(.NV_CYCLES(NVC), .SHADOW_A_INIT(7'd20), .SHADOW_B_INIT(8'd128)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_nv(cmd_nv), .cmd_data(cmd_data), .wel(wel), .tap_req(tap_req),
        .tap_code(tap_code), .wiper_a(wiper_a), .wiper_b(wiper_b), .busy(busy)
    );

    function automatic int ref_code(int i);
        if (i < 0)  return 0;
        if (i > 99) return 96;
        if (i < 25) return i;
        if (i < 50) return 88 - i;
        if (i < 75) return i + 14;
        return 195 - i;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(logic sel, logic nv, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_sel = sel; cmd_nv = nv; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_nv = 1'b0; cmd_sel = 1'b0; cmd_data = 8'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    int cycles;

    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1 busy", int'(busy), 1);
        chk("R1 wiper_a", int'(wiper_a), 0);
        chk("R1 wiper_b", int'(wiper_b), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: recall from shadows
        chk("R2 busy", int'(busy), 0);
        chk("R2 wiper_a", int'(wiper_a), 20);
        chk("R2 wiper_b", int'(wiper_b), 128);

        // R9: exhaustive encoder sweep
        for (int i = -128; i < 128; i++) begin
            tap_req = 8'(i);
            #1;
            chk("R9 tap_code", int'(tap_code), ref_code(i));
        end

        // R3/R8: volatile writes with arbitrary bit changes
        send(1'b0, 1'b0, 8'h7F);
        chk("R3 wiper_a", int'(wiper_a), 127);
        chk("R3 wiper_b untouched", int'(wiper_b), 128);
        send(1'b0, 1'b0, 8'hC0);
        chk("R8 wiper_a all bits", int'(wiper_a), 64);
        send(1'b1, 1'b0, 8'h55);
        chk("R3 wiper_b", int'(wiper_b), 85);
        chk("R3 wiper_a untouched", int'(wiper_a), 64);
        send(1'b1, 1'b0, 8'hAA);
        chk("R8 wiper_b flip", int'(wiper_b), 170);

        // R4: volatile write does not survive reset
        do_reset();
        chk("R4 wiper_a recall", int'(wiper_a), 20);
        chk("R4 wiper_b recall", int'(wiper_b), 128);

        // R5: nonvolatile write without latch
        wel = 1'b0;
        send(1'b1, 1'b1, 8'h3C);
        chk("R5 busy", int'(busy), 0);
        chk("R5 wiper_b", int'(wiper_b), 128);
        do_reset();
        chk("R5 shadow_b", int'(wiper_b), 128);

        // R6/R7: nonvolatile write with latch, command during busy
        wel = 1'b1;
        send(1'b1, 1'b1, 8'h3C);
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            if (cycles == 2) begin
                cmd_valid = 1'b1; cmd_sel = 1'b0; cmd_nv = 1'b0; cmd_data = 8'h11;
            end else begin
                cmd_valid = 1'b0; cmd_data = 8'd0;
            end
            chk("R7 wiper_b held", int'(wiper_b), 128);
            chk("R7 wiper_a held", int'(wiper_a), 20);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R6 busy length", cycles, NVC);
        chk("R6 wiper_b", int'(wiper_b), 60);
        chk("R7 wiper_a ignored", int'(wiper_a), 20);

        send(1'b0, 1'b1, 8'h9B);
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            @(negedge clk);
        end
        chk("R6 busy length A", cycles, NVC);
        chk("R6 wiper_a", int'(wiper_a), 27);
        wel = 1'b0;
        send(1'b0, 1'b0, 8'h05);
        do_reset();
        chk("R6 shadow_a", int'(wiper_a), 27);
        chk("R6 shadow_b", int'(wiper_b), 60);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule